// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block is the transmit DMA engine of an Ethernet MAC. Software builds a ring of 8-byte buffer descriptors in memory, gives each one to the engine by setting its ready flag, and then writes the activate register. The engine fetches descriptors one after another and reads the buffer each one names. It sends the buffer bytes out on a byte-wide valid/ready stream and writes each descriptor back with its ready flag cleared. Several buffers make one frame, up to and including the buffer whose descriptor carries the last flag. A frame that would grow past 2032 bytes is cut at that size and a babble event is raised.

Memory is reached through one 32-bit request/response port that has one read outstanding at a time. A request is held until `mem_req_ready` accepts it. A read is answered by one `mem_rsp_valid` beat in a later cycle. A write is complete when it is accepted. On the byte stream, `tx_valid`, `tx_data` and `tx_last` stay stable while `tx_ready` is low, and a byte moves in each cycle in which both are high. The engine stalls freely on either port.

Software reaches three registers through the `cfg_*` port:
- The control register (offset 0x024) holds the enable bit.
- The activate register (offset 0x014) starts a walk.
- The ring start register (offset 0x184) sets where the ring begins.

Reads are combinational. Registers that are not listed read as 0.

Top module: `tx_ring_walker`

## Requirements
- R1: After reset the engine is idle:
  - `busy`, `tx_valid`, `mem_req_valid` and all event outputs are 0.
  - The ring start register reads 0.
- R2: The activate register (0x014) always reads 0. A write to it starts a walk only while bit 1 of the control register (0x024) is set. Otherwise the write is dropped and no memory request follows. Clearing the enable bit discards an activate that has not yet started.
- R3: A write to the ring start register (0x184) stores the value with bits 1:0 forced to 0, reads back that value, and moves the current descriptor pointer to it.
- R4: A descriptor consists of two big-endian 32-bit words:
  - word 0 holds flags in bits 31:16 and byte length in bits 15:0;
  - word 1 holds the buffer byte address.
  Flag bit 15 (ready) gives the descriptor to the engine. A walk ends at the first descriptor whose ready bit is clear, and the pointer stays on that descriptor.
- R5: Buffer data is read as aligned 32-bit words and sent lowest address first. The byte at address A sits in bits 31-8*(A mod 4) down to 24-8*(A mod 4) of its word. Any start address and any length are sent exactly.
- R6: Flag bit 11 (last) ends a frame. `tx_last` is high only on the final byte of a last buffer, and `ev_frame_done` pulses when that descriptor is written back. Buffers without bit 11 are joined into the same frame.
- R7: After a descriptor with flag bit 13 (wrap), the next fetch uses the ring start address. Otherwise the next fetch uses the current address plus 8.
- R8: After each buffer, word 0 of its descriptor is written back with bit 15 cleared and the length unchanged, and `ev_buf_done` pulses for one cycle.
- R9: When a buffer would take the frame past 2032 bytes, only the bytes that fit are sent and `ev_babble` pulses once. The byte count starts again after a last buffer.
- R10: An activate write that arrives while a walk is in progress is kept. The ring is polled again once that walk ends, with no further write.
- R11: While `tx_valid` is high and `tx_ready` is low, the stream outputs hold. While `mem_req_valid` is high and `mem_req_ready` is low, the request holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | 32 | Byte address, word aligned |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| ev_buf_done | output | 1 | Pulse: buffer finished |
| ev_frame_done | output | 1 | Pulse: frame finished |
| ev_babble | output | 1 | Pulse: frame cut at the size limit |
| busy | output | 1 | Walk running or pending |

## Verification
The hardest case to reach from the ports is the pending activate of R10. Its effect shows only when a descriptor turns ready after the walker has found it not ready but before the walker polls again.

The bench's memory model sets the ready bit of a chosen descriptor right after it serves the first read of that word. The stream is held back so that the second activate lands while the first frame is still in flight. Only a correct re-poll then sends the second frame.

The babble cut needs a frame of more than 2032 bytes spread over two buffers. The bench also checks that the size count starts again on the following frame.

// File: rtl/tx_ring_pkg.sv
package tx_ring_pkg;
  localparam int TXR_FLG_READY = 15;
  localparam int TXR_FLG_WRAP  = 13;
  localparam int TXR_FLG_LAST  = 11;
  localparam int TXR_CTRL_EN   = 1;

  localparam logic [9:0] TXR_OFS_KICK = 10'h014;
  localparam logic [9:0] TXR_OFS_CTRL = 10'h024;
  localparam logic [9:0] TXR_OFS_RING = 10'h184;

  typedef enum logic [3:0] {
    S_IDLE,
    S_D0_REQ,
    S_D0_RSP,
    S_D1_REQ,
    S_D1_RSP,
    S_B_REQ,
    S_B_RSP,
    S_B_OUT,
    S_WB
  } walk_st_t;
endpackage

// File: rtl/txr_cfg.sv
module txr_cfg
  import tx_ring_pkg::*;
#(
  parameter int REG_AW = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [REG_AW-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic              take,
  output logic [31:0]       rdata,
  output logic [31:0]       ring_base,
  output logic              ptr_load,
  output logic [31:0]       ptr_val,
  output logic              kick_pend
);
  logic        en_q;
  logic        pend_q;
  logic [31:0] ring_q;
  logic        wr_kick, wr_ctrl, wr_ring;

  assign wr_kick  = we && (addr == REG_AW'(TXR_OFS_KICK));
  assign wr_ctrl  = we && (addr == REG_AW'(TXR_OFS_CTRL));
  assign wr_ring  = we && (addr == REG_AW'(TXR_OFS_RING));

  assign ptr_load  = wr_ring;
  assign ptr_val   = {wdata[31:2], 2'b00};
  assign ring_base = ring_q;
  assign kick_pend = pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      pend_q <= 1'b0;
      ring_q <= '0;
    end else begin
      if (wr_ctrl) en_q <= wdata[TXR_CTRL_EN];
      if (wr_ring) ring_q <= {wdata[31:2], 2'b00};
      if (wr_kick && en_q)                      pend_q <= 1'b1;
      else if (wr_ctrl && !wdata[TXR_CTRL_EN])  pend_q <= 1'b0;
      else if (take)                            pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == REG_AW'(TXR_OFS_CTRL))      rdata[TXR_CTRL_EN] = en_q;
    else if (addr == REG_AW'(TXR_OFS_RING)) rdata = ring_q;
  end

  AST_KICK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> en_q); // R2
endmodule

// File: rtl/txr_clip.sv
module txr_clip #(
  parameter int MAX_FRAME = 2032,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic [CNT_W-1:0] fcnt,
  input  logic [15:0]      len,
  output logic [15:0]      clip_len,
  output logic             babble
);
  localparam logic [15:0] MAXV = 16'(MAX_FRAME);
  logic [15:0] room;

  assign room     = MAXV - {{(16-CNT_W){1'b0}}, fcnt};
  assign babble   = len > room;
  assign clip_len = babble ? room : len;
endmodule

// File: rtl/txr_lane.sv
module txr_lane (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [1:0]  off,
  input  logic [2:0]  cnt,
  input  logic        last_in,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        idle
);
  logic [31:0] word_q;
  logic [1:0]  idx_q;
  logic [2:0]  left_q;
  logic        last_q;
  logic [7:0]  bytes [4];

  for (genvar g = 0; g < 4; g++) begin : g_byte
    assign bytes[g] = word_q[31-8*g -: 8];
  end

  assign tx_valid = (left_q != 3'd0);
  assign tx_data  = bytes[idx_q];
  assign tx_last  = last_q && (left_q == 3'd1);
  assign idle     = (left_q == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      word_q <= word;
      idx_q  <= off;
      left_q <= cnt;
      last_q <= last_in;
    end else if (tx_valid && tx_ready) begin
      idx_q  <= idx_q + 2'd1;
      left_q <= left_q - 3'd1;
    end
  end

  AST_TX_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R11
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> left_q == 3'd0); // R5
endmodule

// File: rtl/txr_walk.sv
module txr_walk
  import tx_ring_pkg::*;
#(
  parameter int MAX_FRAME = 2032,
  parameter int CNT_W     = $clog2(MAX_FRAME + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        kick_pend,
  output logic        take,
  input  logic [31:0] ring_base,
  input  logic        ptr_load,
  input  logic [31:0] ptr_val,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic        mem_req_write,
  output logic [31:0] mem_req_addr,
  output logic [31:0] mem_req_wdata,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data,
  output logic        lane_load,
  output logic [31:0] lane_word,
  output logic [1:0]  lane_off,
  output logic [2:0]  lane_cnt,
  output logic        lane_last,
  input  logic        lane_idle,
  output logic        ev_buf_done,
  output logic        ev_frame_done,
  output logic        ev_babble,
  output logic        walking
);
  localparam logic [15:0] OWN_CLR = ~(16'h1 << TXR_FLG_READY);

  walk_st_t         st;
  logic [31:0]      ptr_q;
  logic [15:0]      flags_q;
  logic [15:0]      len_q;
  logic [15:0]      rem_q;
  logic [31:0]      baddr_q;
  logic [CNT_W-1:0] fcnt_q;
  logic             ev_buf_q, ev_frm_q, ev_bab_q;

  logic [15:0] clip_len;
  logic        clip_bab;
  logic [2:0]  head, nbytes;

  txr_clip #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_clip (
    .fcnt     (fcnt_q),
    .len      (len_q),
    .clip_len (clip_len),
    .babble   (clip_bab)
  );

  assign head   = 3'd4 - {1'b0, baddr_q[1:0]};
  assign nbytes = (rem_q < {13'd0, head}) ? rem_q[2:0] : head;

  assign take          = (st == S_IDLE) && kick_pend;
  assign walking       = (st != S_IDLE);
  assign mem_req_valid = (st == S_D0_REQ) || (st == S_D1_REQ) ||
                         (st == S_B_REQ) || (st == S_WB);
  assign mem_req_write = (st == S_WB);
  assign mem_req_wdata = {flags_q & OWN_CLR, len_q};

  always_comb begin
    case (st)
      S_D1_REQ: mem_req_addr = ptr_q + 32'd4;
      S_B_REQ:  mem_req_addr = {baddr_q[31:2], 2'b00};
      default:  mem_req_addr = ptr_q;
    endcase
  end

  assign lane_load = (st == S_B_RSP) && mem_rsp_valid;
  assign lane_word = mem_rsp_data;
  assign lane_off  = baddr_q[1:0];
  assign lane_cnt  = nbytes;
  assign lane_last = flags_q[TXR_FLG_LAST] && (rem_q == {13'd0, nbytes});

  assign ev_buf_done   = ev_buf_q;
  assign ev_frame_done = ev_frm_q;
  assign ev_babble     = ev_bab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ptr_q    <= '0;
      flags_q  <= '0;
      len_q    <= '0;
      rem_q    <= '0;
      baddr_q  <= '0;
      fcnt_q   <= '0;
      ev_buf_q <= 1'b0;
      ev_frm_q <= 1'b0;
      ev_bab_q <= 1'b0;
    end else begin
      ev_buf_q <= 1'b0;
      ev_frm_q <= 1'b0;
      ev_bab_q <= 1'b0;
      case (st)
        S_IDLE:   if (kick_pend) st <= S_D0_REQ;
        S_D0_REQ: if (mem_req_ready) st <= S_D0_RSP;
        S_D0_RSP: if (mem_rsp_valid) begin
          flags_q <= mem_rsp_data[31:16];
          len_q   <= mem_rsp_data[15:0];
          st      <= mem_rsp_data[16+TXR_FLG_READY] ? S_D1_REQ : S_IDLE;
        end
        S_D1_REQ: if (mem_req_ready) st <= S_D1_RSP;
        S_D1_RSP: if (mem_rsp_valid) begin
          baddr_q  <= mem_rsp_data;
          rem_q    <= clip_len;
          ev_bab_q <= clip_bab;
          fcnt_q   <= fcnt_q + clip_len[CNT_W-1:0];
          st       <= (clip_len == 16'd0) ? S_WB : S_B_REQ;
        end
        S_B_REQ:  if (mem_req_ready) st <= S_B_RSP;
        S_B_RSP:  if (mem_rsp_valid) begin
          rem_q   <= rem_q - {13'd0, nbytes};
          baddr_q <= baddr_q + {29'd0, nbytes};
          st      <= S_B_OUT;
        end
        S_B_OUT:  if (lane_idle) st <= (rem_q == 16'd0) ? S_WB : S_B_REQ;
        S_WB:     if (mem_req_ready) begin
          ev_buf_q <= 1'b1;
          ev_frm_q <= flags_q[TXR_FLG_LAST];
          if (flags_q[TXR_FLG_LAST]) fcnt_q <= '0;
          ptr_q <= flags_q[TXR_FLG_WRAP] ? ring_base : ptr_q + 32'd8;
          st    <= S_D0_REQ;
        end
        default:  st <= S_IDLE;
      endcase
      if (ptr_load) ptr_q <= ptr_val;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !ptr_load |=>
      mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr)); // R11
  AST_DESC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && (st != S_B_REQ) |-> mem_req_addr[1:0] == 2'b00); // R3
  AST_FRAME_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt_q <= CNT_W'(MAX_FRAME)); // R9
  AST_FRAME_HAS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame_done |-> ev_buf_done); // R6
endmodule

// File: rtl/tx_ring_walker.sv
module tx_ring_walker
  import tx_ring_pkg::*;
#(
  parameter int MAX_FRAME = 2032,
  parameter int REG_AW    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [REG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [31:0]       mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              ev_buf_done,
  output logic              ev_frame_done,
  output logic              ev_babble,
  output logic              busy
);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);

  logic        take, kick_pend, ptr_load, walking;
  logic [31:0] ring_base, ptr_val;
  logic        lane_load, lane_last, lane_idle;
  logic [31:0] lane_word;
  logic [1:0]  lane_off;
  logic [2:0]  lane_cnt;

  txr_cfg #(.REG_AW(REG_AW)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_we),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .take      (take),
    .rdata     (cfg_rdata),
    .ring_base (ring_base),
    .ptr_load  (ptr_load),
    .ptr_val   (ptr_val),
    .kick_pend (kick_pend)
  );

  txr_walk #(.MAX_FRAME(MAX_FRAME), .CNT_W(CNT_W)) u_walk (
    .clk           (clk),
    .rst_n         (rst_n),
    .kick_pend     (kick_pend),
    .take          (take),
    .ring_base     (ring_base),
    .ptr_load      (ptr_load),
    .ptr_val       (ptr_val),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .lane_load     (lane_load),
    .lane_word     (lane_word),
    .lane_off      (lane_off),
    .lane_cnt      (lane_cnt),
    .lane_last     (lane_last),
    .lane_idle     (lane_idle),
    .ev_buf_done   (ev_buf_done),
    .ev_frame_done (ev_frame_done),
    .ev_babble     (ev_babble),
    .walking       (walking)
  );

  txr_lane u_lane (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (lane_load),
    .word     (lane_word),
    .off      (lane_off),
    .cnt      (lane_cnt),
    .last_in  (lane_last),
    .tx_ready (tx_ready),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_last  (tx_last),
    .idle     (lane_idle)
  );

  assign busy = walking || kick_pend;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !tx_valid); // R1
endmodule

// File: tb/tb_tx_ring_walker.sv
module tb_tx_ring_walker;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 150000;
  localparam logic [9:0] A_KICK = 10'h014;
  localparam logic [9:0] A_CTRL = 10'h024;
  localparam logic [9:0] A_RING = 10'h184;
  localparam logic [15:0] F_R = 16'h8000, F_W = 16'h2000, F_L = 16'h0800;
  localparam int NV = 8;
  // [31:16] buffer address, [15:4] length, [0] stall
  localparam logic [31:0] VEC [NV] = '{
    32'h0100_0010, 32'h0201_0031, 32'h0302_0060, 32'h0403_0091,
    32'h0500_0040, 32'h0601_0400, 32'h0702_0401, 32'h0803_0020 };

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [9:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
  logic [31:0] mem_req_addr, mem_req_wdata, mem_rsp_data;
  logic tx_valid, tx_ready, tx_last, ev_buf_done, ev_frame_done, ev_babble, busy;
  logic [7:0] tx_data;

  logic [31:0] mem [2048];
  logic [7:0] got_q[$], exp_q[$];
  logic       lst_q[$];
  int nchk = 0, nfail = 0, cyc = 0, nreq = 0, nbuf = 0, nfrm = 0, nbab = 0;
  logic stall = 1'b0, rsp_pend = 1'b0, arm_on = 1'b0;
  logic [31:0] rsp_addr = '0, arm_addr = '0;

  tx_ring_walker dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .tx_last(tx_last), .ev_buf_done(ev_buf_done),
    .ev_frame_done(ev_frame_done), .ev_babble(ev_babble), .busy(busy));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    mem_rsp_valid = 1'b0; mem_rsp_data = '0; mem_req_ready = 1'b1; tx_ready = 1'b1;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
  end

  // memory model, stream sink and event counters, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (rsp_pend) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = mem[rsp_addr[12:2]];
      rsp_pend = 1'b0;
      if (arm_on && rsp_addr == arm_addr) begin
        mem[arm_addr[12:2]][31] = 1'b1;
        arm_on = 1'b0;
      end
    end
    mem_req_ready = stall ? (cyc % 3 != 0) : 1'b1;
    if (mem_req_valid && mem_req_ready) begin
      nreq++;
      if (mem_req_write) mem[mem_req_addr[12:2]] = mem_req_wdata;
      else begin rsp_pend = 1'b1; rsp_addr = mem_req_addr; end
    end
    tx_ready = stall ? (cyc % 4 != 1) : 1'b1;
    if (tx_valid && tx_ready) begin got_q.push_back(tx_data); lst_q.push_back(tx_last); end
    if (ev_buf_done) nbuf++;
    if (ev_frame_done) nfrm++;
    if (ev_babble) nbab++;
  end

  always @(negedge clk) begin
    if (cyc == WD_LIMIT) begin
      nchk++; nfail++;
      $display("FAIL watchdog: run hung at cycle %0d", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
      $finish;
    end
  end

  task automatic chk(input string rq, input logic ok, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [9:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic put_desc(input logic [31:0] at, input logic [15:0] fl,
                          input logic [15:0] ln, input logic [31:0] ba);
    mem[at[12:2]] = {fl, ln};
    mem[at[12:2] + 11'd1] = ba;
  endtask

  task automatic fill_buf(input logic [31:0] ba, input int len, input int seed, input int npush);
    for (int i = 0; i < len; i++) begin
      logic [31:0] a;
      logic [7:0] b;
      a = ba + 32'(i);
      b = 8'(seed + i * 13);
      mem[a[12:2]][31 - 8*int'(a[1:0]) -: 8] = b;
      if (i < npush) exp_q.push_back(b);
    end
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_stream(input string rq, input int nlast);
    int mism, lc;
    mism = 0; lc = 0;
    chk(rq, got_q.size() == exp_q.size(), "byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      if (got_q[i] !== exp_q[i]) mism++;
    chk(rq, mism == 0, "data mismatches", mism, 0);
    for (int i = 0; i < lst_q.size(); i++) if (lst_q[i]) lc++;
    chk(rq, lc == nlast, "last markers", lc, nlast);
    if (lst_q.size() > 0)
      chk(rq, lst_q[lst_q.size()-1] == 1'b1, "last on final byte", lst_q[lst_q.size()-1], 1);
    got_q.delete(); exp_q.delete(); lst_q.delete();
  endtask

  initial begin
    logic [31:0] rd;
    int b0, f0, k0, r0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", busy == 1'b0, "busy", busy, 0);
    chk("R1", tx_valid == 1'b0 && mem_req_valid == 1'b0, "valids", {tx_valid, mem_req_valid}, 0);
    chk("R1", {ev_buf_done, ev_frame_done, ev_babble} == 3'b0, "events",
        {ev_buf_done, ev_frame_done, ev_babble}, 0);
    reg_rd(A_RING, rd);
    chk("R1", rd == 32'h0, "ring start", rd, 0);

    // R3 ring start alignment and readback
    reg_wr(A_RING, 32'h0000_0043);
    reg_rd(A_RING, rd);
    chk("R3", rd == 32'h40, "ring readback", rd, 32'h40);

    // R2 activate ignored while disabled
    put_desc(32'h40, F_R | F_L | F_W, 16'd4, 32'h900);
    r0 = nreq;
    reg_wr(A_KICK, 32'h1);
    repeat (20) @(negedge clk);
    chk("R2", nreq == r0, "requests while disabled", nreq - r0, 0);
    chk("R2", busy == 1'b0, "busy while disabled", busy, 0);
    reg_rd(A_KICK, rd);
    chk("R2", rd == 32'h0, "activate reads", rd, 0);
    reg_wr(A_CTRL, 32'h2);
    reg_rd(A_CTRL, rd);
    chk("R2", rd[1] == 1'b1, "enable bit", rd[1], 1);

    // table-driven single-buffer frames (R5, R8, R11)
    for (int v = 0; v < NV; v++) begin
      logic [31:0] ba;
      int ln;
      ba = {16'h0, VEC[v][31:16]};
      ln = int'(VEC[v][15:4]);
      stall = VEC[v][0];
      reg_wr(A_RING, 32'h40);
      fill_buf(ba, ln, v * 31 + 1, ln);
      put_desc(32'h40, F_R | F_L | F_W, 16'(ln), ba);
      b0 = nbuf; f0 = nfrm;
      reg_wr(A_KICK, 32'h1);
      wait_idle();
      stall = 1'b0;
      check_stream(VEC[v][0] ? "R11" : "R5", 1);
      chk("R8", mem[32'h40 >> 2] == {F_W | F_L, 16'(ln)}, "write-back word", mem[32'h40 >> 2],
          {F_W | F_L, 16'(ln)});
      chk("R8", nbuf - b0 == 1, "buffer events", nbuf - b0, 1);
      chk("R6", nfrm - f0 == 1, "frame events", nfrm - f0, 1);
    end

    // R6 gather, R4 stop on a free descriptor, R7 linear advance
    reg_wr(A_RING, 32'h40);
    put_desc(32'h40, F_R, 16'd5, 32'h801);
    put_desc(32'h48, F_R, 16'd2, 32'h902);
    put_desc(32'h50, F_R | F_L, 16'd7, 32'hA03);
    put_desc(32'h58, 16'h0, 16'd0, 32'h0);
    fill_buf(32'h801, 5, 3, 5);
    fill_buf(32'h902, 2, 40, 2);
    fill_buf(32'hA03, 7, 77, 7);
    b0 = nbuf; f0 = nfrm;
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    check_stream("R6", 1);
    chk("R6", nbuf - b0 == 3, "gather buffers", nbuf - b0, 3);
    chk("R6", nfrm - f0 == 1, "gather frames", nfrm - f0, 1);
    chk("R4", mem[32'h58 >> 2] == 32'h0, "free desc untouched", mem[32'h58 >> 2], 0);
    put_desc(32'h58, F_R | F_L, 16'd3, 32'hB00);
    fill_buf(32'hB00, 3, 9, 3);
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    check_stream("R4", 1);

    // R7 wrap to ring start
    reg_wr(A_RING, 32'h200);
    put_desc(32'h200, F_R | F_L, 16'd4, 32'hC00);
    put_desc(32'h208, F_R | F_L | F_W, 16'd3, 32'hC10);
    fill_buf(32'hC00, 4, 11, 4);
    fill_buf(32'hC10, 3, 21, 3);
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    check_stream("R7", 2);
    put_desc(32'h200, F_R | F_L, 16'd2, 32'hC20);
    fill_buf(32'hC20, 2, 99, 2);
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    check_stream("R7", 1);

    // R9 babble cut at 2032 bytes, then count restarts
    reg_wr(A_RING, 32'h300);
    put_desc(32'h300, F_R, 16'd1500, 32'h1000);
    put_desc(32'h308, F_R | F_L | F_W, 16'd1000, 32'h1600);
    fill_buf(32'h1000, 1500, 5, 1500);
    fill_buf(32'h1600, 1000, 6, 532);
    k0 = nbab;
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    check_stream("R9", 1);
    chk("R9", nbab - k0 == 1, "babble events", nbab - k0, 1);
    chk("R9", mem[32'h308 >> 2] == {F_W | F_L, 16'd1000}, "write-back length",
        mem[32'h308 >> 2], {F_W | F_L, 16'd1000});
    put_desc(32'h300, F_R | F_L | F_W, 16'd10, 32'h1A00);
    fill_buf(32'h1A00, 10, 50, 10);
    k0 = nbab;
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    check_stream("R9", 1);
    chk("R9", nbab - k0 == 0, "no babble after restart", nbab - k0, 0);

    // R10 activate during a walk causes a re-poll
    reg_wr(A_RING, 32'h400);
    put_desc(32'h400, F_R | F_L, 16'd40, 32'hD00);
    put_desc(32'h408, F_L | F_W, 16'd6, 32'hD40);
    fill_buf(32'hD00, 40, 7, 40);
    fill_buf(32'hD40, 6, 8, 6);
    arm_addr = 32'h408; arm_on = 1'b1;
    stall = 1'b1;
    f0 = nfrm;
    reg_wr(A_KICK, 32'h1);
    repeat (10) @(negedge clk);
    reg_wr(A_KICK, 32'h1);
    wait_idle();
    stall = 1'b0;
    check_stream("R10", 2);
    chk("R10", nfrm - f0 == 2, "frames after re-poll", nfrm - f0, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
    $finish;
  end
endmodule